// File: doc/BRIEF.md
# Backlight PWM Generator with Power-of-Two Prescaler

This block drives one pulse-width-modulated output for a display backlight. Software sets it up through a small write/read register port. It chooses an 8-bit compare value, an output polarity, a power-of-two clock divider and one of two clock sources. The two sources arrive as clock-enable ticks, one slow and one from the system clock, rather than as separate clocks. After the divider, an 8-bit counter steps once per prescaled tick. A period is therefore always 256 prescaled ticks, and the compare value sets how many of those ticks the output is active. The highest duty is 255/256, so a fully active output is never produced.

Starting and stopping use two separate write-one registers, one to start and one to stop. A status bit shows whether the channel is really running. That bit changes only at a period boundary, so a requester polls it after each request. Configuration writes go to a working copy. The counter logic loads that copy at the start of each period, so a write never produces a cut-short or stretched period.

Top module: `bklt_pwm`

## Requirements
- R1: The registers sit at these word addresses:
  - Address 0 holds the compare value in bits 15:8, the polarity in bit 4 and the divider select in bits 2:0.
  - Address 1 holds the source select in bit 0.
  - Address 2 is the start register and address 3 is the stop register.
  - Address 4 holds the status in bit 0.
  Reads return the stored field values. Every other bit reads 0, and addresses 2 and 3 read as 0.
- R2: With polarity 1, the output is high while the counter is below the compare value. A compare value of 0 keeps the output low. At a compare value of 255 the output is low on the last count, so a fully high period never occurs.
- R3: With divider select n, one period lasts 256·2^n source ticks, and the output is high for compare·2^n of them.
- R4: Divider select 7 behaves exactly like divider select 6.
- R5: Source select 0 steps the divider on slowTick, and source select 1 steps it on sysTick.
- R6: With polarity 0, the output is inverted, so it is high for (256 − compare)·2^n source ticks of each period.
- R7: A write to address 2 with bit 0 set starts a stopped channel. A write to address 3 with bit 0 set requests a stop. A write to either address with bit 0 clear has no effect.
- R8: On start, the counter begins at 0 and the output starts toggling at once. The status bit rises at the first period boundary, 256 prescaled ticks after the start write. After a stop request, the output keeps running to the end of the current period, and the status bit falls at that boundary.
- R9: While stopped, the output sits at the inactive level, which is the inverse of the polarity last loaded into the working copy.
- R10: Changes to the compare value, polarity, divider select or source select take effect only at the next period start or at a start, never in the middle of a period.
- R11: A start write that arrives while a stop request is pending cancels the stop, and the channel keeps running.
- R12: A synchronous reset clears every register, stops the channel, reads back all zeros and drives the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slowTick | input | 1 | Clock-enable tick of the slow source |
| sysTick | input | 1 | Clock-enable tick of the system source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| pwmOut | output | 1 | PWM output |

## Verification
- **Divider or counter faults.** A wrong divider mask or a miscounting counter changes how many cycles the output is high within one period. A one-period window catches this no later than one period after the working copy is loaded.
- **Handshake faults.** A flaw in the start/stop handshake moves the status edge away from the exact cycle 256 prescaled ticks after the start write. It can also leave the output at the wrong idle level right after the stop boundary, where a single sample catches it.
- **Working-copy faults.** If the working copy loaded at the wrong time, the partial period after a mid-period compare write would already show the new duty, and the bench compares that partial period against the old value.

// File: rtl/bklt_pwm_pkg.sv
package bklt_pwm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CMP_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_MAX  = 6;
  localparam int PRE_W   = PS_MAX;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;
  localparam int PS_LSB  = 0;
  localparam int SRC_BIT = 0;
  localparam int GO_BIT  = 0;

  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_SRC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_ON   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_OFF  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(4);

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
    logic             srcSys;
  } pwmCfg_t;

  typedef struct packed {
    logic start;
    logic run;
  } pwmStrobe_t;

  // Working copy after reset: normal polarity, so the idle level is low.
  localparam pwmCfg_t SHADOW_RST = '{cmp: '0, pol: 1'b1, ps: '0, srcSys: 1'b0};
endpackage

// File: rtl/bklt_pwm_ctrl.sv
module bklt_pwm_ctrl
  import bklt_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              boundary,
  output logic [DATA_W-1:0] rdData,
  output pwmCfg_t           cfg,
  output pwmStrobe_t        strobe,
  output logic              statusBit
);
  logic running;
  logic statusQ;
  logic stopReq;
  logic onHit;
  logic offHit;
  logic stopNext;
  logic unusedBits;

  assign onHit  = wrEn && (wrAddr == ADR_ON)  && wrData[GO_BIT];
  assign offHit = wrEn && (wrAddr == ADR_OFF) && wrData[GO_BIT];

  // A stop request wins over a start in the same cycle; a start cancels a
  // pending stop.
  always_comb begin
    if (offHit)     stopNext = 1'b1;
    else if (onHit) stopNext = 1'b0;
    else            stopNext = stopReq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      running <= 1'b0;
      statusQ <= 1'b0;
      stopReq <= 1'b0;
    end else begin
      if (wrEn && (wrAddr == ADR_CFG)) begin
        cfg.cmp <= wrData[CMP_LSB +: CMP_W];
        cfg.pol <= wrData[POL_BIT];
        cfg.ps  <= wrData[PS_LSB +: PS_W];
      end
      if (wrEn && (wrAddr == ADR_SRC)) begin
        cfg.srcSys <= wrData[SRC_BIT];
      end

      if (!running) begin
        if (onHit) begin
          running <= 1'b1;
          stopReq <= 1'b0;
        end
      end else if (boundary) begin
        stopReq <= 1'b0;
        if (stopNext) begin
          running <= 1'b0;
          statusQ <= 1'b0;
        end else begin
          statusQ <= 1'b1;
        end
      end else begin
        stopReq <= stopNext;
      end
    end
  end

  always_comb begin
    strobe.start = !running && onHit;
    strobe.run   = running;
  end

  assign statusBit = statusQ;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_CFG: begin
        rdData[CMP_LSB +: CMP_W] = cfg.cmp;
        rdData[POL_BIT]          = cfg.pol;
        rdData[PS_LSB +: PS_W]   = cfg.ps;
      end
      ADR_SRC:  rdData[SRC_BIT] = cfg.srcSys;
      ADR_STAT: rdData[GO_BIT]  = statusQ;
      default:  rdData = '0;
    endcase
  end

  assign unusedBits = ^{wrData[DATA_W-1:CMP_LSB+CMP_W], wrData[POL_BIT-1:PS_LSB+PS_W],
                        wrData[CMP_LSB-1:POL_BIT+1]};
endmodule

// File: rtl/bklt_pwm_dp.sv
module bklt_pwm_dp
  import bklt_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slowTick,
  input  logic             sysTick,
  input  pwmCfg_t          cfg,
  input  pwmStrobe_t       strobe,
  output logic             boundary,
  output logic [CMP_W-1:0] cnt,
  output logic             idlePol,
  output logic             pwmOut
);
  pwmCfg_t          sh;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] mask;
  logic [PS_W-1:0]  effPs;
  logic             srcTick;
  logic             step;
  logic             active;

  // Reserved divider select values above the maximum are clamped.
  assign effPs = (sh.ps > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : sh.ps;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(effPs));
    end
  end

  assign srcTick  = sh.srcSys ? sysTick : slowTick;
  assign step     = strobe.run && srcTick && (preCnt == mask);
  assign boundary = step && (cnt == {CMP_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= SHADOW_RST;
      cnt    <= '0;
      preCnt <= '0;
    end else if (strobe.start) begin
      sh     <= cfg;
      cnt    <= '0;
      preCnt <= '0;
    end else if (strobe.run) begin
      if (srcTick) begin
        preCnt <= step ? '0 : preCnt + 1'b1;
      end
      if (step) begin
        cnt <= cnt + 1'b1;
      end
      if (boundary) begin
        sh <= cfg;
      end
    end
  end

  assign active  = (cnt < sh.cmp);
  assign idlePol = sh.pol;
  assign pwmOut  = strobe.run ? (sh.pol ? active : !active) : !sh.pol;
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
  import bklt_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  logic              sysTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  pwmCfg_t          cfg;
  pwmStrobe_t       strobe;
  logic             boundary;
  logic             statusBit;
  logic             running;
  logic             idlePol;
  logic [CMP_W-1:0] cnt;

  bklt_pwm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .boundary  (boundary),
    .rdData    (rdData),
    .cfg       (cfg),
    .strobe    (strobe),
    .statusBit (statusBit)
  );

  bklt_pwm_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .slowTick (slowTick),
    .sysTick  (sysTick),
    .cfg      (cfg),
    .strobe   (strobe),
    .boundary (boundary),
    .cnt      (cnt),
    .idlePol  (idlePol),
    .pwmOut   (pwmOut)
  );

  assign running = strobe.run;
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk
  import bklt_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrGo,
  input logic              pwmOut,
  input logic              boundary,
  input logic              running,
  input logic              statusBit,
  input logic [CMP_W-1:0]  cnt,
  input logic              idlePol
);
  // R8: status only moves on the edge that closes a period
  assert_status_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(statusBit) |-> $past(boundary));

  // R9: a stopped channel sits at the inverse of its latched polarity
  assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
    !running |-> (pwmOut == !idlePol));

  // R3: the period counter holds or advances by one while running
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> ((cnt == $past(cnt)) || (cnt == ($past(cnt) + 8'd1))));

  // R2: the last count of a period is never active
  assert_no_full_duty_R2: assert property (@(posedge clk) disable iff (rst)
    (running && idlePol && (cnt == {CMP_W{1'b1}})) |-> !pwmOut);

  // R7: a start write with bit 0 clear leaves a stopped channel stopped
  assert_quiet_start_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr == ADR_ON) && !wrGo && !running) |=> !running);

  // R12: reset leaves the output low and the channel stopped
  assert_reset_low_R12: assert property (@(posedge clk)
    rst |=> (!pwmOut && !statusBit && !running));
endmodule

bind bklt_pwm bklt_pwm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrGo      (wrData[0]),
  .pwmOut    (pwmOut),
  .boundary  (boundary),
  .running   (running),
  .statusBit (statusBit),
  .cnt       (cnt),
  .idlePol   (idlePol)
);

// File: tb/tb_bklt_pwm.sv
`timescale 1ns/1ps
module tb_bklt_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slowTick = 1'b0;
  logic        sysTick = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = 3'd4;
  logic [31:0] rdData;
  logic        pwmOut;

  int tests = 0;
  int fails = 0;

  bklt_pwm dut (
    .clk(clk), .rst(rst), .slowTick(slowTick), .sysTick(sysTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #2.5 clk = ~clk;

  // slowTick: one pulse every 4 clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      slowTick = (ph == 0);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
    rdAddr = 3'd4;
    #0.5;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) hi++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cfgWord(input int cmp, input int pol, input int ps);
    return (32'(cmp) << 8) | (32'(pol) << 4) | 32'(ps);
  endfunction

  task automatic cfgRun(input int cmp, input int pol, input int ps, input int oldPer,
                        input int newPer, input int expHi, input string tag);
    int hi;
    wr(3'd0, cfgWord(cmp, pol, ps));
    repeat (oldPer + 4) @(negedge clk);
    measure(newPer, hi);
    chk(tag, hi, expHi);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 out after reset", pwmOut, 0);
    rd(3'd0, v); chk("R12 cfg reads 0", v, 0);
    rd(3'd1, v); chk("R12 src reads 0", v, 0);
    rd(3'd4, v); chk("R12 status reads 0", v, 0);

    // R1 register map and readback
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R1 cfg field readback", v, 32'h0000_FF17);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 src readback", v, 1);
    rd(3'd2, v); chk("R1 start reg reads 0", v, 0);
    rd(3'd3, v); chk("R1 stop reg reads 0", v, 0);
    chk("R12 out idle before start", pwmOut, 0);

    // R8 start timing: counter from 0, status rises 256 counts later
    wr(3'd0, cfgWord(100, 1, 0));
    wr(3'd2, 32'h1);
    chk("R8 status low right after start", rdData[0], 0);
    measure(255, hi);
    chk("R8 status low before first boundary", rdData[0], 0);
    if (pwmOut) hi++;
    @(negedge clk);
    chk("R8 status high at first boundary", rdData[0], 1);
    chk("R2 first period duty", hi, 100);

    // R2/R3 duty sweep, divider 0
    for (int c = 0; c < 256; c += 17) cfgRun(c, 1, 0, 256, 256, c, "R2 duty sweep");
    cfgRun(128, 1, 0, 256, 256, 128, "R2 half duty");

    // R3 divider sweep
    cfgRun(37, 1, 1, 256, 512, 74, "R3 divider 1");
    cfgRun(37, 1, 2, 512, 1024, 148, "R3 divider 2");
    cfgRun(37, 1, 3, 1024, 2048, 296, "R3 divider 3");
    // R4 reserved select 7 behaves as 6
    cfgRun(64, 1, 7, 2048, 16384, 4096, "R4 select 7 as 6");
    cfgRun(50, 1, 0, 16384, 256, 50, "R3 back to divider 0");

    // R5 slow source: 4 clocks per tick
    wr(3'd1, 32'h0);
    cfgRun(50, 1, 0, 256, 1024, 200, "R5 slow source");
    wr(3'd1, 32'h1);
    cfgRun(50, 1, 0, 1024, 256, 50, "R5 system source");

    // R6 inverted polarity
    cfgRun(60, 0, 0, 256, 256, 196, "R6 inverted duty");
    cfgRun(0, 0, 0, 256, 256, 256, "R6 inverted zero compare");

    // stop, then restart aligned for the R10 check
    wr(3'd0, cfgWord(200, 1, 0));
    wr(3'd3, 32'h1);
    repeat (600) @(negedge clk);
    chk("R8 status low after stop", rdData[0], 0);
    chk("R9 idle low for polarity 1", pwmOut, 0);

    // R10 mid-period compare write waits for the next period
    wr(3'd2, 32'h1);
    repeat (50) @(negedge clk);
    wr(3'd0, cfgWord(10, 1, 0));
    measure(204, hi);
    chk("R10 old compare kept to period end", hi, 148);
    measure(256, hi);
    chk("R10 new compare in next period", hi, 10);

    // R8/R9 stop lag and idle level from latched polarity
    wr(3'd0, cfgWord(10, 0, 0));
    wr(3'd3, 32'h1);
    chk("R8 status still high after stop request", rdData[0], 1);
    repeat (251) @(negedge clk);
    chk("R8 status high until boundary", rdData[0], 1);
    @(negedge clk);
    chk("R8 status low at boundary", rdData[0], 0);
    chk("R9 idle high for polarity 0", pwmOut, 1);

    // R7 writes without bit 0 do nothing
    wr(3'd2, 32'h0);
    wr(3'd2, 32'h2);
    repeat (300) @(negedge clk);
    chk("R7 zero start write ignored status", rdData[0], 0);
    chk("R7 zero start write ignored output", pwmOut, 1);

    // R11 start cancels a pending stop; R7 zero stop write ignored
    wr(3'd0, cfgWord(128, 1, 0));
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h0);
    repeat (300) @(negedge clk);
    chk("R7 zero stop write ignored", rdData[0], 1);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h1);
    repeat (600) @(negedge clk);
    chk("R11 stop cancelled status", rdData[0], 1);
    measure(256, hi);
    chk("R11 still running duty", hi, 128);

    wr(3'd3, 32'h1);
    repeat (600) @(negedge clk);
    chk("R8 final stop status", rdData[0], 0);
    chk("R9 final idle low", pwmOut, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule